// File: doc/BRIEF.md
# Dual-Range Translation Table Selector

This block decides which of two translation table base regions an incoming I/O virtual address belongs to. Region 0 covers a low window whose upper address bits are all zero, and region 1 covers a high window whose upper address bits are all one. Each window is sized by its own size field, which counts how many of the most significant address bits take part in the check. Each region also has its own top-byte-ignore enable. When that enable applies, the 8 most significant address bits are not checked. The result goes to a table walker. The walker starts from the base of the selected region, or it raises a translation fault when the address falls between the two windows.

A size field of zero has a special meaning. The region with a zero size field claims every address that the other region does not claim. A request is a one-cycle strobe with the address and configuration. One cycle later the block returns a registered result with a valid strobe. The result holds until the next request.

Top module: `tsel_top`

## Requirements
- R1: `vld_o` is 1 in the cycle after each cycle in which `req_i` is 1, and 0 otherwise. After reset `vld_o`, `region_o` and `fault_o` are 0.
- R2: Address bit `ADDR_W-1-IGN_W` (bit 55 at the default width) selects which top-byte-ignore enable applies. A 1 selects `tbi1_i` and a 0 selects `tbi0_i`. This holds whichever region is eventually chosen.
- R3: When the selected top-byte-ignore enable is 1, the `IGN_W` most significant address bits are left out of both range checks. If a size field is no larger than `IGN_W`, the corresponding check covers no bits and matches.
- R4: If `tsz0_i` is nonzero and the checked bits `[ADDR_W-1-ign : ADDR_W-tsz0_i]` are all zero, then `region_o`=0 and `fault_o`=0. This takes priority over region 1.
- R5: Otherwise, if `tsz1_i` is nonzero and the checked bits `[ADDR_W-1-ign : ADDR_W-tsz1_i]` are all one, then `region_o`=1 and `fault_o`=0.
- R6: Otherwise, if `tsz0_i` is zero, then `region_o`=0 and `fault_o`=0. This includes the case where both size fields are zero.
- R7: Otherwise, if `tsz1_i` is zero, then `region_o`=1 and `fault_o`=0.
- R8: Otherwise, when both size fields are nonzero and neither check matches, `fault_o`=1 and `region_o`=0.
- R9: In a cycle with `req_i`=0, `region_o` and `fault_o` keep their values at the next edge, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe; the inputs below are sampled when it is 1 |
| addr_i | input | ADDR_W | I/O virtual address |
| tsz0_i | input | $clog2(ADDR_W) | Region 0 size field (number of checked top bits) |
| tsz1_i | input | $clog2(ADDR_W) | Region 1 size field |
| tbi0_i | input | 1 | Top-byte-ignore enable used when the selector bit is 0 |
| tbi1_i | input | 1 | Top-byte-ignore enable used when the selector bit is 1 |
| vld_o | output | 1 | Result valid, one cycle after the request |
| region_o | output | 1 | Selected region (0 or 1); 0 on a fault |
| fault_o | output | 1 | Translation fault: address lies between the regions |

## Verification
The bench builds the block with `ADDR_W`=16 and `IGN_W`=8. This makes the size fields 4 bits wide and puts the ignore-selector bit at position 7. At that width every pair of size fields and every combination of the two ignore enables can be swept in full. Each such configuration is paired with addresses that are all zeros or all ones, with one bit flipped at each position. That places a one-bit deviation on each side of every window boundary. It also toggles the selector bit independently of the checked bits, so the priority rules, the zero-size defaults, the empty checks and the gap fault are all reached.

// File: rtl/tsel_range_chk.sv
module tsel_range_chk #(
  parameter int ADDR_W = 64,
  parameter int IGN_W  = 8,
  parameter bit ONES   = 1'b0,
  localparam int TSZ_W = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  tsz_i,
  input  logic              ign_top_i,
  output logic              hit_o
);
  // Bits that take part in the check: from ADDR_W-tsz upward,
  // stopping below the ignored top byte when that is active.
  function automatic logic [ADDR_W-1:0] chk_mask(input int tsz, input int ign);
    logic [ADDR_W-1:0] m;
    for (int p = 0; p < ADDR_W; p++) begin
      m[p] = (p >= ADDR_W - tsz) && (p < ADDR_W - ign);
    end
    return m;
  endfunction

  logic [ADDR_W-1:0] mask;
  logic              cond;

  always_comb begin
    mask = chk_mask(int'(tsz_i), ign_top_i ? IGN_W : 0);
    if (ONES) cond = ((addr_i & mask) == mask);
    else      cond = ((addr_i & mask) == '0);
  end

  assign hit_o = (tsz_i != '0) && cond;
endmodule

// File: rtl/tsel_pick.sv
module tsel_pick (
  input  logic hit0_i,
  input  logic hit1_i,
  input  logic tsz0_zero_i,
  input  logic tsz1_zero_i,
  output logic region_o,
  output logic fault_o
);
  always_comb begin
    region_o = 1'b0;
    fault_o  = 1'b0;
    if (hit0_i)           region_o = 1'b0;
    else if (hit1_i)      region_o = 1'b1;
    else if (tsz0_zero_i) region_o = 1'b0;
    else if (tsz1_zero_i) region_o = 1'b1;
    else                  fault_o  = 1'b1;
  end
endmodule

// File: rtl/tsel_top.sv
module tsel_top #(
  parameter int ADDR_W = 64,
  parameter int IGN_W  = 8,
  localparam int TSZ_W = $clog2(ADDR_W),
  localparam int SEL_BIT = ADDR_W - 1 - IGN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TSZ_W-1:0]  tsz0_i,
  input  logic [TSZ_W-1:0]  tsz1_i,
  input  logic              tbi0_i,
  input  logic              tbi1_i,
  output logic              vld_o,
  output logic              region_o,
  output logic              fault_o
);
  logic             ign_top;
  logic [1:0]       hit;
  logic [TSZ_W-1:0] tsz_arr [2];
  logic             region_nx;
  logic             fault_nx;

  // R2: selector bit picks which ignore enable applies
  assign ign_top = addr_i[SEL_BIT] ? tbi1_i : tbi0_i;
  assign tsz_arr[0] = tsz0_i;
  assign tsz_arr[1] = tsz1_i;

  for (genvar r = 0; r < 2; r++) begin : g_chk
    tsel_range_chk #(
      .ADDR_W (ADDR_W),
      .IGN_W  (IGN_W),
      .ONES   (r == 1)
    ) chk_i (
      .addr_i    (addr_i),
      .tsz_i     (tsz_arr[r]),
      .ign_top_i (ign_top),
      .hit_o     (hit[r])
    );
  end

  tsel_pick pick_i (
    .hit0_i      (hit[0]),
    .hit1_i      (hit[1]),
    .tsz0_zero_i (tsz0_i == '0),
    .tsz1_zero_i (tsz1_i == '0),
    .region_o    (region_nx),
    .fault_o     (fault_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      region_o <= 1'b0;
      fault_o  <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        region_o <= region_nx;
        fault_o  <= fault_nx;
      end
    end
  end

  p_vld_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  p_no_vld_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !vld_o);
  p_r0_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && hit[0]) |=> (!region_o && !fault_o));
  p_r1_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !hit[0] && hit[1]) |=> (region_o && !fault_o));
  p_fault_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_nx |-> (!hit[0] && !hit[1] && tsz0_i != '0 && tsz1_i != '0));
  p_fault_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !region_o);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(region_o) && $stable(fault_o)));
endmodule

// File: tb/tsel_top_tb_top.sv
module tsel_top_tb_top;
  localparam int W   = 16;
  localparam int IGN = 8;
  localparam int TW  = $clog2(W);
  localparam int SB  = W - 1 - IGN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [W-1:0]  addr = '0;
  logic [TW-1:0] tsz0 = '0;
  logic [TW-1:0] tsz1 = '0;
  logic          tbi0 = 1'b0;
  logic          tbi1 = 1'b0;
  logic          vld, region, fault;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tsel_top #(.ADDR_W(W), .IGN_W(IGN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .addr_i(addr),
    .tsz0_i(tsz0), .tsz1_i(tsz1), .tbi0_i(tbi0), .tbi1_i(tbi1),
    .vld_o(vld), .region_o(region), .fault_o(fault)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h tsz0=%0d tsz1=%0d tbi=%b%b act{vld,reg,flt}=%b exp=%b",
               tag, addr, tsz0, tsz1, tbi1, tbi0, act, exp);
    end
  endtask

  // Independent model: count mismatching bits in each checked span.
  task automatic model(input logic [W-1:0] a, input int t0, input int t1,
                       input bit b0, input bit b1,
                       output bit rg, output bit fl, output string tag);
    int  ign;
    int  bad0, bad1;
    bit  in0, in1;
    ign = (a[SB] ? b1 : b0) ? IGN : 0;
    bad0 = 0; bad1 = 0;
    for (int p = W - t0; p < W - ign; p++) if (a[p] != 1'b0) bad0++;
    for (int p = W - t1; p < W - ign; p++) if (a[p] != 1'b1) bad1++;
    in0 = (t0 != 0) && (bad0 == 0);
    in1 = (t1 != 0) && (bad1 == 0);
    fl = 1'b0;
    if (in0)          begin rg = 1'b0; tag = "R4 (R2 R3)"; end
    else if (in1)     begin rg = 1'b1; tag = "R5 (R2 R3)"; end
    else if (t0 == 0) begin rg = 1'b0; tag = "R6"; end
    else if (t1 == 0) begin rg = 1'b1; tag = "R7"; end
    else              begin rg = 1'b0; fl = 1'b1; tag = "R8"; end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    bit    erg, efl;
    string tag;
    logic  prg, pfl;
    repeat (3) @(negedge clk);
    check("R1 reset", {vld, region, fault}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {vld, region, fault}, 3'b000);

    for (int t0 = 0; t0 < (1 << TW); t0++) begin
      for (int t1 = 0; t1 < (1 << TW); t1++) begin
        for (int tb = 0; tb < 4; tb++) begin
          tsz0 = TW'(t0); tsz1 = TW'(t1);
          tbi0 = tb[0];   tbi1 = tb[1];
          for (int k = 0; k < 2 * (W + 1); k++) begin
            logic [W-1:0] base;
            base = (k >= W + 1) ? '1 : '0;
            if ((k % (W + 1)) < W) base[k % (W + 1)] = ~base[k % (W + 1)];
            addr = base;
            req  = 1'b1;
            model(addr, t0, t1, tbi0, tbi1, erg, efl, tag);
            @(negedge clk);
            check({tag, " R1"}, {vld, region, fault}, {1'b1, erg, efl});
          end
          // R9: idle cycle with changed inputs must not disturb result
          prg = region; pfl = fault;
          req  = 1'b0;
          addr = ~addr;
          tsz0 = ~tsz0;
          @(negedge clk);
          check("R9 hold (R1 no strobe)", {vld, region, fault}, {1'b0, prg, pfl});
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule